// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block decides, for every channel of a bank of timer/counter channels, which signal drives the channel's count clock and which signal drives its gate. The channels come in groups of three. Each channel holds two 3-bit selector codes, one for the clock and one for the gate. Both codes are written and read back over a small register port.

The clock can come from one of these sources:
- the channel's own clock pin;
- one of five decade-spaced internal rates;
- the output of the channel just before it;
- an external clock pin shared by the channel's group.

The gate can be forced on or off, taken from the channel's own gate pin, or taken from the inverted output of the channel two places before it.

All channels form a single ring. Channel i is channel n of group i/3. The channel before channel 0 is the last channel of the highest group, so both chained links wrap across group and bank boundaries. The internal rates are single-cycle enable pulses derived from a divide-by-ten chain that runs on the base clock. The block also drives the direction control of each channel's clock and gate pins. The counters themselves sit outside the block and are seen here only as their output levels.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every clock code and every gate code is 0. Each channel then follows its own clock pin, its gate is high, its clock pin is an input and its gate pin is an output.
- R2: When wr_en is high on a clock edge, wr_code is stored for channel wr_chan: into its gate selector if wr_gate=1, otherwise into its clock selector. rd_code shows the stored code of rd_chan (gate selector if rd_gate=1) from the next cycle on, reserved codes included. A write to a channel number of NCH or more is ignored, and a read of such a number returns 0.
- R3: Clock code 0 routes clk_pin_in[i] to cnt_clk[i]. Clock code 7 routes grp_ext_clk[i/3].
- R4: Clock code c in 1..5 gives an enable that is high for one base cycle out of every 10^(c-1). It is high in the cycle after the k-th rising edge since reset release when k mod 10^(c-1) equals 10^(c-1)-1. Code 1 is therefore always high.
- R5: Clock code 6 routes ctr_out[(i-1) mod NCH]. For channel 0 this is the last channel of the highest group.
- R6: Gate code 0 gives a constant 1, gate code 1 a constant 0, and gate code 2 routes gat_pin_in[i].
- R7: Gate code 3 routes the inverse of ctr_out[(i-2) mod NCH]. This is channel 0 of the same group for n=2, and channel n+1 of the preceding group for n<2.
- R8: Gate codes 4 to 7 hold cnt_gate[i] at 0.
- R9: clk_pin_oe[i] is 1 exactly when the clock code is not 0. gat_pin_oe[i] is 1 exactly when the gate code is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 10 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Selector write strobe |
| wr_chan | input | $clog2(NCH) | Channel number for the write |
| wr_gate | input | 1 | 1 writes the gate selector, 0 writes the clock selector |
| wr_code | input | 3 | Code to store |
| rd_chan | input | $clog2(NCH) | Channel number for readback |
| rd_gate | input | 1 | 1 reads the gate selector, 0 reads the clock selector |
| rd_code | output | 3 | Readback code |
| clk_pin_in | input | NCH | Per-channel dedicated clock pins |
| gat_pin_in | input | NCH | Per-channel dedicated gate pins |
| grp_ext_clk | input | GROUPS | Group-shared external clock pins |
| ctr_out | input | NCH | Counter output levels |
| cnt_clk | output | NCH | Selected clock for each channel |
| cnt_gate | output | NCH | Selected gate for each channel |
| clk_pin_oe | output | NCH | 1 drives the channel's clock pin as an output |
| gat_pin_oe | output | NCH | 1 drives the channel's gate pin as an output |

## Verification
The bench aims at the ring seams. It checks that channel 0's chained clock comes from the last channel of the highest group, and that the inverted-output gates of channels 0 and 1 reach back into the previous group. A design that closed the chain inside each group would route the wrong counter there.

The bench tracks the phase of the divided enables over more than two periods of the slowest rate. An off-by-one divider, or a stage that does not wait for its slower neighbour, would move a pulse away from the cycle the bench predicts.

It also writes reserved gate codes and channel numbers past the last channel. A design that let a reserved code open the gate, or that wrapped an out-of-range write onto a real channel, would show a wrong gate or a changed readback.

// File: rtl/ctr_route_pkg.sv
`timescale 1ns/1ps
package ctr_route_pkg;
   localparam int CODE_W     = 3;
   localparam int CH_PER_GRP = 3;
   localparam int N_RATES    = 5;
   typedef logic [CODE_W-1:0] src_code_t;

   localparam src_code_t CK_PIN     = 3'd0;
   localparam src_code_t CK_CHAIN   = 3'd6;
   localparam src_code_t CK_GRP_EXT = 3'd7;

   localparam src_code_t GT_ON      = 3'd0;
   localparam src_code_t GT_OFF     = 3'd1;
   localparam src_code_t GT_PIN     = 3'd2;
   localparam src_code_t GT_CHAIN   = 3'd3;
endpackage

// File: rtl/ctr_decade_prescaler.sv
`timescale 1ns/1ps
module ctr_decade_prescaler #(
   parameter int DIV    = 10,
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES:0]   rate_en
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   initial begin
      assert (DIV >= 2) else $error("prescaler ratio must be at least 2");
      assert (STAGES >= 1) else $error("prescaler needs at least one stage");
   end

   assign rate_en[0] = 1'b1;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)          cnt <= '0;
         else if (rate_en[s]) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign rate_en[s+1] = rate_en[s] && (cnt == LAST);

      // R4: a divided enable never stays high two cycles running
      assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rate_en[s+1] |=> !rate_en[s+1]);
   end

   // R4: the first divided rate fires exactly DIV cycles apart, counted from reset
   logic [CW-1:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n)          gap <= '0;
      else if (rate_en[1]) gap <= '0;
      else                 gap <= gap + 1'b1;
   end
   assert_rate_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rate_en[1] |-> gap == LAST);
endmodule

// File: rtl/ctr_src_regs.sv
`timescale 1ns/1ps
module ctr_src_regs
   import ctr_route_pkg::*;
#(
   parameter int NCH = 9,
   parameter int AW  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_chan,
   input  logic                  wr_gate,
   input  src_code_t             wr_code,
   input  logic [AW-1:0]         rd_chan,
   input  logic                  rd_gate,
   output src_code_t             rd_code,
   output src_code_t [NCH-1:0]   clk_code,
   output src_code_t [NCH-1:0]   gate_code
);
   localparam logic [AW:0] NCH_W = (AW+1)'(NCH);

   logic wr_ok, rd_ok;
   assign wr_ok = wr_en && ({1'b0, wr_chan} < NCH_W);
   assign rd_ok = {1'b0, rd_chan} < NCH_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_code  <= '0;
         gate_code <= '0;
      end else if (wr_ok) begin
         if (wr_gate) gate_code[wr_chan] <= wr_code;
         else         clk_code[wr_chan]  <= wr_code;
      end
   end

   always_comb begin
      rd_code = '0;
      if (rd_ok) rd_code = rd_gate ? gate_code[rd_chan] : clk_code[rd_chan];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R2: a write to channel i lands in the selected selector on the next cycle
      assert_clk_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_chan == AW'(i) && !wr_gate) |=> clk_code[i] == $past(wr_code));
      assert_gate_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_chan == AW'(i) && wr_gate) |=> gate_code[i] == $past(wr_code));
   end
endmodule

// File: rtl/ctr_chan_select.sv
`timescale 1ns/1ps
module ctr_chan_select
   import ctr_route_pkg::*;
(
   input  src_code_t            clk_code,
   input  src_code_t            gate_code,
   input  logic                 pin_clk,
   input  logic                 pin_gat,
   input  logic                 grp_ext,
   input  logic                 prev_out,
   input  logic                 prev2_out,
   input  logic [N_RATES-1:0]   rate_en,
   output logic                 sel_clk,
   output logic                 sel_gate,
   output logic                 clk_oe,
   output logic                 gat_oe
);
   logic [2:0] ridx;
   assign ridx = clk_code - 3'd1;

   always_comb begin
      case (clk_code)
         CK_PIN:     sel_clk = pin_clk;
         CK_CHAIN:   sel_clk = prev_out;
         CK_GRP_EXT: sel_clk = grp_ext;
         default:    sel_clk = rate_en[ridx];
      endcase
   end

   always_comb begin
      case (gate_code)
         GT_ON:    sel_gate = 1'b1;
         GT_OFF:   sel_gate = 1'b0;
         GT_PIN:   sel_gate = pin_gat;
         GT_CHAIN: sel_gate = !prev2_out;
         default:  sel_gate = 1'b0;
      endcase
   end

   assign clk_oe = (clk_code != CK_PIN);
   assign gat_oe = (gate_code != GT_PIN);
endmodule

// File: rtl/ctr_src_router.sv
`timescale 1ns/1ps
module ctr_src_router
   import ctr_route_pkg::*;
#(
   parameter int GROUPS = 3,
   parameter int DECADE = 10
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [$clog2(GROUPS*CH_PER_GRP)-1:0]   wr_chan,
   input  logic                                   wr_gate,
   input  logic [CODE_W-1:0]                      wr_code,
   input  logic [$clog2(GROUPS*CH_PER_GRP)-1:0]   rd_chan,
   input  logic                                   rd_gate,
   output logic [CODE_W-1:0]                      rd_code,
   input  logic [GROUPS*CH_PER_GRP-1:0]           clk_pin_in,
   input  logic [GROUPS*CH_PER_GRP-1:0]           gat_pin_in,
   input  logic [GROUPS-1:0]                      grp_ext_clk,
   input  logic [GROUPS*CH_PER_GRP-1:0]           ctr_out,
   output logic [GROUPS*CH_PER_GRP-1:0]           cnt_clk,
   output logic [GROUPS*CH_PER_GRP-1:0]           cnt_gate,
   output logic [GROUPS*CH_PER_GRP-1:0]           clk_pin_oe,
   output logic [GROUPS*CH_PER_GRP-1:0]           gat_pin_oe
);
   localparam int NCH = GROUPS * CH_PER_GRP;
   localparam int AW  = $clog2(NCH);

   initial begin
      assert (GROUPS >= 1) else $error("router needs at least one group");
   end

   src_code_t [NCH-1:0]  clk_code, gate_code;
   logic [N_RATES-1:0]   rate_en;

   ctr_decade_prescaler #(.DIV(DECADE), .STAGES(N_RATES-1)) u_div (
      .clk(clk), .rst_n(rst_n), .rate_en(rate_en));

   ctr_src_regs #(.NCH(NCH), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_chan(wr_chan), .wr_gate(wr_gate), .wr_code(wr_code),
      .rd_chan(rd_chan), .rd_gate(rd_gate), .rd_code(rd_code),
      .clk_code(clk_code), .gate_code(gate_code));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int PREV  = (i + NCH - 1) % NCH;
      localparam int PREV2 = (i + NCH - 2) % NCH;
      localparam int GRP   = i / CH_PER_GRP;

      ctr_chan_select u_sel (
         .clk_code(clk_code[i]), .gate_code(gate_code[i]),
         .pin_clk(clk_pin_in[i]), .pin_gat(gat_pin_in[i]),
         .grp_ext(grp_ext_clk[GRP]),
         .prev_out(ctr_out[PREV]), .prev2_out(ctr_out[PREV2]),
         .rate_en(rate_en),
         .sel_clk(cnt_clk[i]), .sel_gate(cnt_gate[i]),
         .clk_oe(clk_pin_oe[i]), .gat_oe(gat_pin_oe[i]));

      // R5: the chained clock follows the ring predecessor, across group seams
      assert_chain_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
         clk_code[i] == CK_CHAIN |-> cnt_clk[i] == ctr_out[PREV]);
      // R7: the chained gate is the inverted output two places back
      assert_chain_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
         gate_code[i] == GT_CHAIN |-> cnt_gate[i] == !ctr_out[PREV2]);
      // R6: a forced-off gate stays low
      assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         gate_code[i] == GT_OFF |-> !cnt_gate[i]);
      // R8: reserved gate codes keep the gate closed
      assert_gate_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
         gate_code[i] > GT_CHAIN |-> !cnt_gate[i]);
   end
endmodule

// File: tb/sim_ctr_src_router.sv
`timescale 1ns/1ps
module sim_ctr_src_router;
   localparam int G   = 3;
   localparam int NCH = G * 3;
   localparam int AW  = $clog2(NCH);

   logic clk = 1'b0;
   logic rst_n;
   logic wr_en, wr_gate, rd_gate;
   logic [AW-1:0] wr_chan, rd_chan;
   logic [2:0] wr_code;
   wire  [2:0] rd_code;
   logic [NCH-1:0] clk_pin_in, gat_pin_in, ctr_out;
   logic [G-1:0]   grp_ext_clk;
   wire  [NCH-1:0] cnt_clk, cnt_gate, clk_pin_oe, gat_pin_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int unsigned edges;
   int sh_clk [NCH];
   int sh_gate[NCH];

   always #5 clk = ~clk;

   ctr_src_router #(.GROUPS(G)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_gate(wr_gate),
      .wr_code(wr_code), .rd_chan(rd_chan), .rd_gate(rd_gate), .rd_code(rd_code),
      .clk_pin_in(clk_pin_in), .gat_pin_in(gat_pin_in), .grp_ext_clk(grp_ext_clk),
      .ctr_out(ctr_out), .cnt_clk(cnt_clk), .cnt_gate(cnt_gate),
      .clk_pin_oe(clk_pin_oe), .gat_pin_oe(gat_pin_oe));

   always @(posedge clk) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit rate_hit(int k);
      int unsigned p = 1;
      for (int j = 0; j < k; j++) p = p * 10;
      return (edges % p) == p - 1;
   endfunction

   function automatic bit exp_clk(int i);
      int c = sh_clk[i];
      if (c == 0) return clk_pin_in[i];
      if (c == 6) return ctr_out[(i + NCH - 1) % NCH];
      if (c == 7) return grp_ext_clk[i / 3];
      return rate_hit(c - 1);
   endfunction

   function automatic bit exp_gate(int i);
      case (sh_gate[i])
         0: return 1'b1;
         1: return 1'b0;
         2: return gat_pin_in[i];
         3: return !ctr_out[(i + NCH - 2) % NCH];
         default: return 1'b0;
      endcase
   endfunction

   function automatic string clk_req(int c);
      if (c == 0 || c == 7) return "R3";
      if (c == 6) return "R5";
      return "R4";
   endfunction

   function automatic string gate_req(int c);
      if (c <= 2) return "R6";
      if (c == 3) return "R7";
      return "R8";
   endfunction

   task automatic check_all();
      for (int i = 0; i < NCH; i++) begin
         chk(clk_req(sh_clk[i]), $sformatf("cnt_clk[%0d] code %0d", i, sh_clk[i]),
             int'(cnt_clk[i]), int'(exp_clk(i)));
         chk(gate_req(sh_gate[i]), $sformatf("cnt_gate[%0d] code %0d", i, sh_gate[i]),
             int'(cnt_gate[i]), int'(exp_gate(i)));
         chk("R9", $sformatf("clk_pin_oe[%0d]", i), int'(clk_pin_oe[i]), int'(sh_clk[i] != 0));
         chk("R9", $sformatf("gat_pin_oe[%0d]", i), int'(gat_pin_oe[i]), int'(sh_gate[i] != 2));
      end
   endtask

   task automatic check_read(int ch, bit g);
      int exp;
      rd_chan = AW'(ch);
      rd_gate = g;
      #1;
      if (ch >= NCH) exp = 0;
      else           exp = g ? sh_gate[ch] : sh_clk[ch];
      chk("R2", $sformatf("readback chan %0d gate %0d", ch, g), int'(rd_code), exp);
   endtask

   task automatic do_write(int ch, bit g, int code);
      @(negedge clk);
      wr_en = 1'b1; wr_chan = AW'(ch); wr_gate = g; wr_code = 3'(code);
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (ch < NCH) begin
         if (g) sh_gate[ch] = code;
         else   sh_clk[ch]  = code;
      end
   endtask

   task automatic shake_inputs();
      clk_pin_in  = NCH'($urandom);
      gat_pin_in  = NCH'($urandom);
      ctr_out     = NCH'($urandom);
      grp_ext_clk = G'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R1..all watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; wr_en = 1'b0; wr_gate = 1'b0; wr_chan = '0; wr_code = '0;
      rd_chan = '0; rd_gate = 1'b0;
      clk_pin_in = '0; gat_pin_in = '0; ctr_out = '0; grp_ext_clk = '0;
      for (int i = 0; i < NCH; i++) begin sh_clk[i] = 0; sh_gate[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state of selectors, routing and pin directions
      for (int i = 0; i < NCH; i++) begin
         check_read(i, 1'b0);
         check_read(i, 1'b1);
      end
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) shake_inputs();
         #1;
         for (int i = 0; i < NCH; i++) begin
            chk("R1", $sformatf("reset cnt_clk[%0d]", i), int'(cnt_clk[i]), int'(clk_pin_in[i]));
            chk("R1", $sformatf("reset cnt_gate[%0d]", i), int'(cnt_gate[i]), 1);
            chk("R1", $sformatf("reset clk_pin_oe[%0d]", i), int'(clk_pin_oe[i]), 0);
            chk("R1", $sformatf("reset gat_pin_oe[%0d]", i), int'(gat_pin_oe[i]), 1);
         end
      end

      // R2: out-of-range writes change nothing, out-of-range reads give 0
      for (int ch = NCH; ch < (1 << AW); ch++) begin
         do_write(ch, 1'b0, 5);
         do_write(ch, 1'b1, 3);
      end
      for (int ch = 0; ch < (1 << AW); ch++) begin
         check_read(ch, 1'b0);
         check_read(ch, 1'b1);
      end

      // R5/R7: ring seams across group boundaries
      do_write(0, 1'b0, 6);
      do_write(3, 1'b0, 6);
      do_write(0, 1'b1, 3);
      do_write(1, 1'b1, 3);
      do_write(2, 1'b1, 3);
      for (int b = 0; b < NCH; b++) begin
         @(negedge clk) ctr_out = NCH'(1) << b;
         #1;
         chk("R5", "ch0 clock from last channel of top group", int'(cnt_clk[0]), int'(b == NCH-1));
         chk("R5", "ch3 clock from ch2", int'(cnt_clk[3]), int'(b == 2));
         chk("R7", "ch0 gate from inverted ch7", int'(cnt_gate[0]), int'(b != NCH-2));
         chk("R7", "ch1 gate from inverted ch8", int'(cnt_gate[1]), int'(b != NCH-1));
         chk("R7", "ch2 gate from inverted ch0", int'(cnt_gate[2]), int'(b != 0));
         check_all();
      end

      // R8: each reserved gate code closes the gate even with the pin high
      for (int c = 4; c < 8; c++) begin
         do_write(5, 1'b1, c);
         @(negedge clk) gat_pin_in = '1; ctr_out = '0;
         #1 chk("R8", $sformatf("reserved gate code %0d", c), int'(cnt_gate[5]), 0);
         check_read(5, 1'b1);
      end

      // mixed random writes (some out of range, reserved codes included)
      for (int it = 0; it < 400; it++) begin
         do_write($urandom_range(0, (1 << AW) - 1), 1'($urandom), $urandom_range(0, 7));
         @(negedge clk) shake_inputs();
         #1 check_all();
         check_read($urandom_range(0, (1 << AW) - 1), 1'($urandom));
      end

      // R4: every divided rate tracked over more than two periods of the slowest
      for (int i = 0; i < NCH; i++) do_write(i, 1'b0, 1 + (i % 5));
      for (int n = 0; n < 21000; n++) begin
         @(negedge clk) shake_inputs();
         #1 check_all();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule